// File: doc/BRIEF.md
# Thermal interrupt status and mask controller

This block gathers eight independent event sources of a thermal supervisor into a sticky status register and drives an active-low interrupt pin. Each source has an enable bit in an interrupt-mask register and a bit in a lock register. An event whose mask bit is set is accepted: its status bit is set and, unless its lock bit is set, its own mask bit is cleared. This stops the same source from interrupting again while software services it.

Software reaches the block through plain one-cycle strobes. It can write the mask register, write the lock register, read the status register (the read clears it) and acknowledge an alert-response query. The pin is released by either the status read or the acknowledge, and it is driven only while the global interrupt enable is high. Decoding the serial bus and producing the event pulses happen outside this block.

Top module: `thermint_ctrl`

## Requirements
- R1: After reset, status and mask and lock registers all read zero and `int_n_o` is 1.
- R2: An event on source i while mask bit i is 1 sets status bit i at the next clock edge; while mask bit i is 0 the event leaves status and mask unchanged.
- R3: An accepted event clears mask bit i at the same edge, unless lock bit i is 1, in which case mask bit i stays 1.
- R4: Sources are independent: an event on source i touches only bit i of status and mask, whatever the other bits hold or receive in the same cycle.
- R5: A mask write or lock write loads the written value at the next edge; when a mask write and an accepted event coincide, the written mask value wins, and the event is still judged against the mask held before the write.
- R6: `int_n_o` is registered; after an edge at which an event was accepted it is 0 if `gie_i` was 1 at that edge, and it is 1 after any edge at which `gie_i` was 0.
- R7: A status-read strobe clears the status register and releases `int_n_o` to 1 at the next edge, except that an event accepted in the same cycle sets its bit anyway and keeps the interrupt asserted.
- R8: An alert-response acknowledge releases `int_n_o` to 1 at the next edge without changing the status register.
- R9: Status bits are sticky: a set bit stays set across later cycles and later events until a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one per source |
| gie_i | input | 1 | Global interrupt enable |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wd_i | input | 8 | Mask write data |
| lock_wr_i | input | 1 | Lock register write strobe |
| lock_wd_i | input | 8 | Lock write data |
| stat_rd_i | input | 1 | Status read strobe (clears status) |
| ara_ack_i | input | 1 | Alert-response acknowledge strobe |
| status_o | output | 8 | Status register |
| mask_o | output | 8 | Current interrupt-mask register |
| lock_o | output | 8 | Current lock register |
| int_n_o | output | 1 | Active-low interrupt pin |

## Verification
The bench builds the block with its default of eight sources, which keeps every mask value within reach of a full sweep. For each of the 256 mask values it derives an event pattern, a lock pattern and an enable value arithmetically, so every combination of accepted, rejected, locked and unlocked bits appears across the sweep along with both enable states. Directed cases then cover a status read colliding with a new event, a mask write colliding with an event, enabling the interrupt while an event is already pending, and the stickiness of status across later events.

// File: rtl/thermint_pkg.sv
package thermint_pkg;

  // Event accepted when its source is enabled in the mask.
  function automatic logic bit_accept(input logic evt, input logic msk);
    return evt & msk;
  endfunction

  // Mask after an accepted event: cleared unless the lock pins it.
  function automatic logic bit_mask_after(input logic msk, input logic acc,
                                          input logic lck);
    return msk & ~(acc & ~lck);
  endfunction

  // Status next value: a read clears, an accepted event always sets.
  function automatic logic bit_status_next(input logic st, input logic acc,
                                           input logic clr);
    return (st & ~clr) | acc;
  endfunction

endpackage

// File: rtl/thermint_bitcell.sv
module thermint_bitcell
  import thermint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mask_wr,
  input  logic mask_wd,
  input  logic lock_wr,
  input  logic lock_wd,
  input  logic stat_clr,
  output logic mask_q,
  output logic lock_q,
  output logic stat_q,
  output logic acc
);

  logic mask_d;
  logic stat_d;

  assign acc    = bit_accept(evt, mask_q);
  assign mask_d = mask_wr ? mask_wd : bit_mask_after(mask_q, acc, lock_q);
  assign stat_d = bit_status_next(stat_q, acc, stat_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      lock_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (lock_wr) lock_q <= lock_wd;
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/thermint_irq.sv
module thermint_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic any_acc,
  input  logic release_req,
  input  logic gie,
  output logic int_n
);

  logic pend_q;
  logic pend_d;

  assign pend_d = any_acc | (pend_q & ~release_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      int_n  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      int_n  <= ~(pend_d & gie);
    end
  end

endmodule

// File: rtl/thermint_ctrl.sv
module thermint_ctrl #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             gie_i,
  input  logic             mask_wr_i,
  input  logic [N_SRC-1:0] mask_wd_i,
  input  logic             lock_wr_i,
  input  logic [N_SRC-1:0] lock_wd_i,
  input  logic             stat_rd_i,
  input  logic             ara_ack_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] lock_o,
  output logic             int_n_o
);

  logic [N_SRC-1:0] acc_vec;
  logic             any_acc;
  logic             release_req;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    thermint_bitcell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[i]),
      .mask_wr  (mask_wr_i),
      .mask_wd  (mask_wd_i[i]),
      .lock_wr  (lock_wr_i),
      .lock_wd  (lock_wd_i[i]),
      .stat_clr (stat_rd_i),
      .mask_q   (mask_o[i]),
      .lock_q   (lock_o[i]),
      .stat_q   (status_o[i]),
      .acc      (acc_vec[i])
    );
  end

  assign any_acc     = |acc_vec;
  assign release_req = stat_rd_i | ara_ack_i;

  thermint_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_acc     (any_acc),
    .release_req (release_req),
    .gie         (gie_i),
    .int_n       (int_n_o)
  );

endmodule

// File: rtl/thermint_chk.sv
module thermint_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic             gie_i,
  input logic             mask_wr_i,
  input logic             stat_rd_i,
  input logic             ara_ack_i,
  input logic [N_SRC-1:0] status_o,
  input logic [N_SRC-1:0] mask_o,
  input logic [N_SRC-1:0] lock_o,
  input logic             int_n_o
);

  logic [N_SRC-1:0] hit;
  assign hit = evt_i & mask_o;

  a_r2_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(hit)) == $past(hit)));

  a_r2_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(hit)) == '0));

  a_r3_lock_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_i |=> ((mask_o & $past(hit & lock_o)) == $past(hit & lock_o)));

  a_r3_unlocked_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_i |=> ((mask_o & $past(hit & ~lock_o)) == '0));

  a_r6_gie_gates_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> int_n_o);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && hit == '0) |=> (status_o == '0 && int_n_o));

  a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_ack_i && !stat_rd_i && hit == '0) |=> (int_n_o && $stable(status_o)));

  a_r1_pin_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(int_n_o));

endmodule

bind thermint_ctrl thermint_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .gie_i     (gie_i),
  .mask_wr_i (mask_wr_i),
  .stat_rd_i (stat_rd_i),
  .ara_ack_i (ara_ack_i),
  .status_o  (status_o),
  .mask_o    (mask_o),
  .lock_o    (lock_o),
  .int_n_o   (int_n_o)
);

// File: tb/tb_thermint_ctrl.sv
module tb_thermint_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       gie_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_wd_i = '0;
  logic       lock_wr_i = 1'b0;
  logic [7:0] lock_wd_i = '0;
  logic       stat_rd_i = 1'b0;
  logic       ara_ack_i = 1'b0;
  logic [7:0] status_o;
  logic [7:0] mask_o;
  logic [7:0] lock_o;
  logic       int_n_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  thermint_ctrl #(.N_SRC(8)) dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Load mask and lock, clear status and pending with a read.
  task automatic setup(input logic [7:0] m, input logic [7:0] l);
    mask_wr_i = 1'b1; mask_wd_i = m;
    lock_wr_i = 1'b1; lock_wd_i = l;
    stat_rd_i = 1'b1;
    tick();
    mask_wr_i = 1'b0; lock_wr_i = 1'b0; stat_rd_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    check("R1 status", status_o, 8'h00);
    check("R1 mask", mask_o, 8'h00);
    check("R1 lock", lock_o, 8'h00);
    check("R1 int_n", {7'd0, int_n_o}, 8'h01);
    rst_n = 1'b1;
    tick();

    // Sweep over every mask value (R2, R3, R4, R5, R6, R8).
    for (int k = 0; k < 256; k++) begin
      logic [7:0] m, e, l, acc, mexp;
      logic g;
      m = 8'(k);
      e = 8'((k * 37 + 11) & 255);
      l = {m[3:0], m[7:4]} ^ 8'h3C;
      g = (k % 3) != 0;
      acc  = e & m;
      mexp = m & ~(acc & ~l);
      gie_i = g;
      setup(m, l);
      check("R5 mask load", mask_o, m);
      check("R5 lock load", lock_o, l);
      evt_i = e;
      tick();
      evt_i = '0;
      check("R2 R4 status", status_o, acc);
      check("R3 R4 mask", mask_o, mexp);
      check("R6 int_n", {7'd0, int_n_o}, {7'd0, !((acc != 0) && g)});
      ara_ack_i = 1'b1;
      tick();
      ara_ack_i = 1'b0;
      check("R8 int_n released", {7'd0, int_n_o}, 8'h01);
      check("R8 status kept", status_o, acc);
    end

    // R7: read colliding with a new event.
    gie_i = 1'b1;
    setup(8'hFF, 8'h00);
    evt_i = 8'h01; tick(); evt_i = '0;
    stat_rd_i = 1'b1; evt_i = 8'h08; tick();
    stat_rd_i = 1'b0; evt_i = '0;
    check("R7 event survives read", status_o, 8'h08);
    check("R7 int held", {7'd0, int_n_o}, 8'h00);
    stat_rd_i = 1'b1; tick(); stat_rd_i = 1'b0;
    check("R7 read clears", status_o, 8'h00);
    check("R7 int released", {7'd0, int_n_o}, 8'h01);

    // R5: mask write colliding with an accepted event.
    setup(8'hFF, 8'h00);
    mask_wr_i = 1'b1; mask_wd_i = 8'h0F; evt_i = 8'h81; tick();
    mask_wr_i = 1'b0; evt_i = '0;
    check("R5 write wins", mask_o, 8'h0F);
    check("R5 old mask judged", status_o, 8'h81);

    // R6: enable raised while an event is pending.
    gie_i = 1'b0;
    setup(8'hFF, 8'hFF);
    evt_i = 8'h10; tick(); evt_i = '0;
    check("R6 gated off", {7'd0, int_n_o}, 8'h01);
    gie_i = 1'b1; tick();
    check("R6 enable asserts", {7'd0, int_n_o}, 8'h00);
    check("R3 locked mask kept", mask_o, 8'hFF);

    // R9: stickiness across later events.
    evt_i = 8'h02; tick(); evt_i = '0;
    repeat (4) tick();
    check("R9 sticky", status_o, 8'h12);
    // R2: masked-off event ignored.
    setup(8'h00, 8'h00);
    evt_i = 8'hFF; tick(); evt_i = '0;
    check("R2 masked ignored", status_o, 8'h00);
    check("R2 mask unchanged", mask_o, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule